// File: doc/BRIEF.md
# Bus Lock Sequencer for Atomic Read-Modify-Write

This controller turns lock and release commands from the instruction stream into a bus lock for indivisible read-modify-write sequences. Neither command acts on the cycle it arrives. A lock command arms the controller, and the next load or store that misses the cache takes the bus lock. A release command arms the release, and the next load or store of any kind drops the lock. Interrupts stay masked for the whole time the bus is held.

A typical use is test-and-set. Software issues a lock, loads the semaphore (this load takes the lock), issues a release, and then stores the new semaphore value (this store drops the lock). After a release command the controller counts retired instructions. If the instruction budget (32 by default) runs out before any load or store arrives, the controller raises a one-cycle fault, frees the bus and unmasks interrupts.

Top module: `buslk_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `bus_locked`, `irq_mask` and `fault` are all 0.
- R2: After `lock_cmd` is accepted in idle, `bus_locked` rises on the clock edge that samples the first later `mem_access` with `cache_miss`=1. Accesses with `cache_miss`=0 do not lock. An access sampled on the same edge as the accepted `lock_cmd` only arms the controller.
- R3: `irq_mask` equals `bus_locked` in every cycle.
- R4: While locked, `unlock_cmd` arms the release. `bus_locked` falls on the edge that samples the next `mem_access`, hit or miss. Accesses sampled on the edge that accepts `unlock_cmd` do not release.
- R5: If BUDGET (default 32) `retire` strobes are sampled after the accepted `unlock_cmd` with no `mem_access`, `fault` is 1 for exactly one cycle from the edge that samples the last of them. In that cycle `bus_locked` and `irq_mask` are 0, and afterwards the controller is idle.
- R6: A `mem_access` arriving after BUDGET-1 or fewer counted retires releases the bus with no fault. A `retire` sampled together with a `mem_access` is not counted.
- R7: `lock_cmd` is ignored while a lock is armed, held or being released. `unlock_cmd` is ignored while idle and while a release is already armed, so the watchdog count is not restarted.
- R8: `unlock_cmd` while a lock is armed cancels it and returns to idle. This holds even when a cache-miss access arrives on the same edge.
- R9: A `retire` sampled on the edge that accepts `unlock_cmd` is not counted toward the budget.
- R10: While locked, `lock_cmd` and `unlock_cmd` on the same edge are handled as an unlock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_cmd | input | 1 | Lock command strobe |
| unlock_cmd | input | 1 | Release command strobe |
| retire | input | 1 | One instruction retired this cycle |
| mem_access | input | 1 | A load or store executes this cycle |
| cache_miss | input | 1 | The access in this cycle missed the cache |
| bus_locked | output | 1 | External bus lock |
| irq_mask | output | 1 | Interrupt disable while the bus is held |
| fault | output | 1 | One-cycle instruction fault pulse |

## Verification
The bench targets the off-by-one edges of the watchdog. With exactly BUDGET-1 retires followed by a store, there must be no fault, and with BUDGET retires the fault must appear on the edge of the last one. A counter that is off by one would trip early or late. It checks that a cache hit never takes the lock, which a design that locks on any access would do. It also checks that a release does not wait for a miss, which a design that copies the lock condition would get wrong. Same-edge collisions are exercised: cancel versus miss, lock versus unlock, and retire together with unlock or with an access. A wrong priority in any of these shows up as a held bus, a missing fault or a spurious fault.

// File: rtl/buslk_pkg.sv
package buslk_pkg;
   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_ARMED     = 3'd1,
      ST_HELD      = 3'd2,
      ST_RELEASING = 3'd3,
      ST_TRIP      = 3'd4
   } lk_state_t;
endpackage

// File: rtl/buslk_budget.sv
module buslk_budget #(
   parameter int BUDGET   = 32,
   parameter bit COUNT_UP = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic tick,
   output logic expired
);
   localparam int CW   = (BUDGET > 2) ? $clog2(BUDGET) : 1;
   localparam int LAST = BUDGET - 1;

   generate
      if (BUDGET < 2) begin : g_bad_budget
         $error("buslk_budget: BUDGET must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   generate
      if (COUNT_UP) begin : g_up
         assign expired = tick && !clear && (cnt == CW'(LAST));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                cnt <= '0;
            else if (clear)            cnt <= '0;
            else if (tick && !expired) cnt <= cnt + 1'b1;
         end
      end else begin : g_down
         assign expired = tick && !clear && (cnt == '0);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                cnt <= CW'(LAST);
            else if (clear)            cnt <= CW'(LAST);
            else if (tick && !expired) cnt <= cnt - 1'b1;
         end
      end
   endgenerate

   // a fresh budget cannot be spent on the very next strobe
   AST_NO_EARLY_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clear) |-> !expired); // R5
endmodule

// File: rtl/buslk_fsm.sv
module buslk_fsm
   import buslk_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      lock_cmd,
   input  logic      unlock_cmd,
   input  logic      retire,
   input  logic      mem_access,
   input  logic      cache_miss,
   input  logic      expired,
   output logic      cnt_clear,
   output logic      cnt_tick,
   output lk_state_t state
);
   lk_state_t nxt;

   assign cnt_clear = (state == ST_HELD) && unlock_cmd;
   assign cnt_tick  = (state == ST_RELEASING) && retire && !mem_access;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE:      if (lock_cmd) nxt = ST_ARMED;
         ST_ARMED: begin
            if (unlock_cmd)                    nxt = ST_IDLE;
            else if (mem_access && cache_miss) nxt = ST_HELD;
         end
         ST_HELD:      if (unlock_cmd) nxt = ST_RELEASING;
         ST_RELEASING: begin
            if (mem_access)   nxt = ST_IDLE;
            else if (expired) nxt = ST_TRIP;
         end
         ST_TRIP:      nxt = ST_IDLE;
         default:      nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   AST_LOCK_NEEDS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HELD && $past(state) != ST_HELD) |-> $past(mem_access && cache_miss)); // R2
   AST_RELEASE_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && $past(state) == ST_RELEASING) |-> $past(mem_access)); // R4
   AST_TRIP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TRIP) |=> (state == ST_IDLE)); // R5
   AST_TRIP_AFTER_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TRIP) |-> ($past(state) == ST_RELEASING && $past(retire) && !$past(mem_access))); // R5
   AST_IDLE_IGNORES_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == ST_IDLE && !$past(lock_cmd)) |-> (state == ST_IDLE)); // R7
endmodule

// File: rtl/buslk_decode.sv
module buslk_decode
   import buslk_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  lk_state_t state,
   output logic      bus_locked,
   output logic      irq_mask,
   output logic      fault
);
   assign bus_locked = (state == ST_HELD) || (state == ST_RELEASING);
   assign irq_mask   = bus_locked;
   assign fault      = (state == ST_TRIP);

   AST_FAULT_FREES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (!bus_locked && !irq_mask)); // R5
   AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> !fault); // R5
endmodule

// File: rtl/buslk_ctrl.sv
module buslk_ctrl #(
   parameter int BUDGET   = 32,
   parameter bit COUNT_UP = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lock_cmd,
   input  logic unlock_cmd,
   input  logic retire,
   input  logic mem_access,
   input  logic cache_miss,
   output logic bus_locked,
   output logic irq_mask,
   output logic fault
);
   import buslk_pkg::*;

   lk_state_t state;
   logic      cnt_clear, cnt_tick, expired;

   buslk_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .lock_cmd   (lock_cmd),
      .unlock_cmd (unlock_cmd),
      .retire     (retire),
      .mem_access (mem_access),
      .cache_miss (cache_miss),
      .expired    (expired),
      .cnt_clear  (cnt_clear),
      .cnt_tick   (cnt_tick),
      .state      (state)
   );

   buslk_budget #(.BUDGET(BUDGET), .COUNT_UP(COUNT_UP)) u_budget (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (cnt_clear),
      .tick    (cnt_tick),
      .expired (expired)
   );

   buslk_decode u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .state      (state),
      .bus_locked (bus_locked),
      .irq_mask   (irq_mask),
      .fault      (fault)
   );
endmodule

// File: tb/sim_buslk_ctrl.sv
module sim_buslk_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int BUDGET     = 32;

   logic clk = 1'b0, rst_n = 1'b0;
   logic lock_cmd = 0, unlock_cmd = 0, retire = 0, mem_access = 0, cache_miss = 0;
   logic bus_locked, irq_mask, fault;

   int n_tests = 0, n_fail = 0;
   bit done = 0;
   int m_st  = 0;   // 0 idle 1 armed 2 held 3 releasing 4 trip
   int m_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   buslk_ctrl #(.BUDGET(BUDGET)) u0 (
      .clk(clk), .rst_n(rst_n), .lock_cmd(lock_cmd), .unlock_cmd(unlock_cmd),
      .retire(retire), .mem_access(mem_access), .cache_miss(cache_miss),
      .bus_locked(bus_locked), .irq_mask(irq_mask), .fault(fault)
   );

   function automatic int next_state(int s, int c, bit l, bit u, bit r, bit m, bit h);
      case (s)
         0: return l ? 1 : 0;
         1: return u ? 0 : ((m && h) ? 2 : 1);
         2: return u ? 3 : 2;
         3: return m ? 0 : ((r && c == BUDGET-1) ? 4 : 3);
         default: return 0;
      endcase
   endfunction

   function automatic int next_cnt(int s, int c, bit u, bit r, bit m);
      if (s == 2 && u) return 0;
      if (s == 3 && r && !m) return c + 1;
      return c;
   endfunction

   task automatic check(string req);
      logic exp_lk, exp_f;
      exp_lk = (m_st == 2 || m_st == 3);
      exp_f  = (m_st == 4);
      n_tests++;
      if (bus_locked !== exp_lk || irq_mask !== exp_lk || fault !== exp_f) begin
         n_fail++;
         $display("FAIL %s: lock/mask/fault = %b%b%b expected %b%b%b",
                  req, bus_locked, irq_mask, fault, exp_lk, exp_lk, exp_f);
      end
   endtask

   // drive at negedge, model the edge, check at the following negedge
   task automatic step(bit l, bit u, bit r, bit m, bit h, string req);
      int ns, nc;
      lock_cmd = l; unlock_cmd = u; retire = r; mem_access = m; cache_miss = h;
      ns = next_state(m_st, m_cnt, l, u, r, m, h);
      nc = next_cnt(m_st, m_cnt, u, r, m);
      @(posedge clk);
      m_st = ns; m_cnt = nc;
      @(negedge clk);
      check(req);
   endtask

   task automatic go_locked();
      step(1,0,0,0,0,"R2");
      step(0,0,1,1,1,"R2");
   endtask

   task automatic expect_fault(bit e, string req);
      n_tests++;
      if (fault !== e) begin
         n_fail++;
         $display("FAIL %s: fault = %b expected %b", req, fault, e);
      end
   endtask

   initial begin
      #(CLK_PERIOD*200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete, got timeout expected end");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = 32'h1ced;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      check("R1");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1");

      // R2: hit does not lock, miss locks; same-edge miss with lock only arms (R2)
      step(1,0,0,1,1,"R2");
      step(0,0,1,1,0,"R2");
      step(0,0,1,1,1,"R2");
      // R7: second lock while held ignored
      step(1,0,1,0,0,"R7");
      // R4: accept-edge access does not release, next hit releases
      step(0,1,1,1,0,"R4");
      step(0,0,1,1,0,"R4");
      // R7: unlock in idle has no effect
      step(0,1,1,1,1,"R7");
      // R8: cancel beats same-edge miss
      step(1,0,0,0,0,"R8");
      step(0,1,0,1,1,"R8");
      step(0,0,0,1,1,"R8");

      // R6: BUDGET-1 retires then a store releases without fault; R9 retire on unlock edge not counted
      go_locked();
      step(0,1,1,0,0,"R9");
      for (int i = 0; i < BUDGET-1; i++) step(0,0,1,0,0,"R6");
      step(0,0,1,1,0,"R6");
      expect_fault(1'b0, "R6");

      // R5: exact budget trips; R10 lock+unlock acts as unlock; R7 re-unlock does not restart
      go_locked();
      step(1,1,0,0,0,"R10");
      step(0,1,1,0,0,"R7");
      for (int i = 0; i < BUDGET-2; i++) step(0,0,1,0,0,"R5");
      expect_fault(1'b0, "R5");
      step(0,0,1,0,0,"R5");
      expect_fault(1'b1, "R5");
      step(0,0,1,0,0,"R5");
      expect_fault(1'b0, "R5");
      check("R3");

      // random mix against the reference functions
      for (int i = 0; i < 4000; i++) begin
         int mp;
         mp = (i < 2000) ? 15 : 2;
         step(($urandom % 100) < 10, ($urandom % 100) < 8, ($urandom % 100) < 60,
              ($urandom % 100) < mp, ($urandom % 2) == 1, "R3");
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule